// File: doc/BRIEF.md
# Egress Queue Scheduler with Mixed Strict and Weighted Service

This block arbitrates egress service for a few QoS channels, each of which owns eight queues. Every queue signals that it holds at least one packet. When a request pulse names a channel, the block chooses one queue of that channel and returns its index with a valid strobe one cycle later. A channel can serve its queues in three ways: all by strict priority, all by weighted round robin (WRR), or a split in which a leading group of queues is strict and the remaining queues share the leftover bandwidth by WRR.

Software programs the block through a small register port. One register holds a 3-bit service mode for each channel. A second register holds one disable bit for every channel/queue pair. A third register is an indirect command port that loads 16-bit WRR weights. After a write to this port, software polls a done flag until the weight table update is complete. The block does not store packets, move data or shape rates.

Top module: `egress_qsched`

## Requirements
- R1: After reset no grant is issued, the mode, disable and command registers all read zero, and every WRR credit and round-robin pointer is zero.
- R2: A request (`req_valid` high with channel `req_ch`) sampled on a clock edge gives `gnt_valid` high after that same edge, with `gnt_ch` equal to the requested channel. This happens only when the channel has an eligible queue. With no request, or with no eligible queue, `gnt_valid` stays low.
- R3: Queue q of channel c is eligible when `q_ready[c*8+q]` is high and its disable bit is clear. A disabled queue is never granted.
- R4: A channel's mode m sets its strict group to queues 0..n-1. For m=0, n=0 (all eight queues WRR). For m=1, n=8 (all eight queues strict). For m from 2 to 7, n=m-1, which leaves 9-m queues in WRR. A split of seven strict queues and one WRR queue cannot be encoded.
- R5: If any strict queue is eligible, the lowest-numbered eligible strict queue is granted, and the WRR state is left untouched.
- R6: Otherwise the search starts at the channel's pointer and wraps modulo 8. The first eligible WRR queue with nonzero credit is granted and its credit drops by one. The pointer then stays on that queue while it still has credit, and moves to the next index once its credit reaches zero.
- R7: On a WRR decision where no eligible WRR queue holds credit, all eight credits of the channel are reloaded from their weights before the search.
- R8: A weight of 0 reloads as a credit of 1.
- R9: Any write to the mode register clears the credits and pointers of every channel.
- R10: A write to the command register with bit 31 set latches channel bits 23:19, queue bits 18:16 and weight bits 15:0. On the next read, bit 31 (pending) is 1 and bit 30 (done) is 0. One cycle later the table holds the new weight, the read shows pending 0 and done 1, and the latched fields are read back in place. A write to this register with bit 31 clear changes nothing.
- R11: A command whose channel field is not below the number of channels leaves the weight table unchanged but still completes with done.
- R12: Register map: address 0 holds the mode of channel c in bits 4c+2:4c. Address 1 holds the disable bit of channel c, queue q at bit c*8+q. Address 2 is the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| q_ready | input | NUM_CH*8 | Per-queue packet-present flags, bit c*8+q |
| req_valid | input | 1 | Grant request pulse |
| req_ch | input | CH_W | Channel being requested |
| gnt_valid | output | 1 | A queue was granted |
| gnt_ch | output | CH_W | Channel of the grant |
| gnt_q | output | 3 | Granted queue index |

## Verification
A corrupted credit or pointer does not show up at once. It appears at the ports as a grant sequence that departs from the weighted pattern, at the first WRR decision that consults the bad value. That can be as late as one full reload round, so the bench compares every grant against its reference on every clock. A wrong strict count or a wrong disable bit shows up on the very next request that touches the affected queue. A stale or misrouted weight write shows up in the done and readback fields two cycles after the command, and in the grant pattern after the next credit reload.

// File: rtl/egress_qsched_pkg.sv
package egress_qsched_pkg;
    localparam int QPC      = 8;
    localparam int QIDX_W   = 3;
    localparam int MODE_W   = 3;
    localparam int WT_W     = 16;
    localparam int CMD_BIT  = 31;
    localparam int DONE_BIT = 30;
    localparam int CH_LO    = 19;
    localparam int CH_FW    = 5;
    localparam int Q_LO     = 16;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_DIS  = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;

    // number of strict queues selected by a mode code
    function automatic logic [3:0] strict_count(input logic [MODE_W-1:0] m);
        logic [3:0] n;
        case (m)
            3'd0:    n = 4'd0;
            3'd1:    n = 4'd8;
            default: n = {1'b0, m} - 4'd1;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/egress_qsched_cfg.sv
module egress_qsched_cfg
    import egress_qsched_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    output logic [NUM_CH*MODE_W-1:0]      mode,
    output logic [NUM_CH*QPC-1:0]         dis,
    output logic [NUM_CH*QPC-1:0][WT_W-1:0] wt,
    output logic                          mode_clr,
    output logic                          pend,
    output logic                          done
);
    localparam int NQ = NUM_CH * QPC;

    typedef struct packed {
        logic [NUM_CH*MODE_W-1:0]  mode;
        logic [NQ-1:0]             dis;
        logic [NQ-1:0][WT_W-1:0]   wt;
        logic                      pend;
        logic                      done;
        logic [CH_FW-1:0]          cmd_ch;
        logic [QIDX_W-1:0]         cmd_q;
        logic [WT_W-1:0]           cmd_wt;
    } cfg_t;

    cfg_t s_d, s_q;
    logic clr_d;

    always_comb begin
        int slot;
        s_d   = s_q;
        clr_d = 1'b0;
        slot  = int'(s_q.cmd_ch) * QPC + int'(s_q.cmd_q);
        // complete a pending weight command
        if (s_q.pend) begin
            s_d.pend = 1'b0;
            s_d.done = 1'b1;
            if (int'(s_q.cmd_ch) < NUM_CH) begin
                s_d.wt[slot] = s_q.cmd_wt;
            end
        end
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_MODE: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        s_d.mode[c*MODE_W +: MODE_W] = cfg_wdata[c*4 +: MODE_W];
                    end
                    clr_d = 1'b1;
                end
                ADDR_DIS: begin
                    s_d.dis = cfg_wdata[NQ-1:0];
                end
                ADDR_CMD: begin
                    if (cfg_wdata[CMD_BIT]) begin
                        s_d.pend   = 1'b1;
                        s_d.done   = 1'b0;
                        s_d.cmd_ch = cfg_wdata[CH_LO +: CH_FW];
                        s_d.cmd_q  = cfg_wdata[Q_LO +: QIDX_W];
                        s_d.cmd_wt = cfg_wdata[WT_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
        end else begin
            s_q      <= s_d;
        end
    end

    assign mode_clr = clr_d;
    assign mode     = s_q.mode;
    assign dis      = s_q.dis;
    assign wt       = s_q.wt;
    assign pend     = s_q.pend;
    assign done     = s_q.done;

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_MODE: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    cfg_rdata[c*4 +: MODE_W] = s_q.mode[c*MODE_W +: MODE_W];
                end
            end
            ADDR_DIS: cfg_rdata[NQ-1:0] = s_q.dis;
            ADDR_CMD: begin
                cfg_rdata[CMD_BIT]           = s_q.pend;
                cfg_rdata[DONE_BIT]          = s_q.done;
                cfg_rdata[CH_LO +: CH_FW]    = s_q.cmd_ch;
                cfg_rdata[Q_LO +: QIDX_W]    = s_q.cmd_q;
                cfg_rdata[WT_W-1:0]          = s_q.cmd_wt;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/egress_qsched_chan.sv
module egress_qsched_chan
    import egress_qsched_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      sel,
    input  logic [MODE_W-1:0]         mode,
    input  logic [QPC-1:0][WT_W-1:0]  wt,
    input  logic [QPC-1:0]            elig,
    output logic                      hit,
    output logic [QIDX_W-1:0]         hit_q
);
    typedef struct packed {
        logic [QPC-1:0][WT_W-1:0] credit;
        logic [QIDX_W-1:0]        ptr;
    } wrr_t;

    wrr_t s_d, s_q;

    logic [3:0]               n_strict;
    logic [QPC-1:0]           strict_m;
    logic [QPC-1:0]           wrr_el;
    logic                     s_hit;
    logic [QIDX_W-1:0]        s_q_idx;
    logic                     live;
    logic [QPC-1:0][WT_W-1:0] eff;
    logic                     w_hit;
    logic [QIDX_W-1:0]        w_q_idx;
    logic [QIDX_W-1:0]        idx;
    logic [WT_W-1:0]          left;

    // group split and strict pick
    always_comb begin
        n_strict = strict_count(mode);
        s_hit    = 1'b0;
        s_q_idx  = '0;
        for (int q = QPC-1; q >= 0; q--) begin
            strict_m[q] = (q < int'(n_strict));
            wrr_el[q]   = elig[q] && !strict_m[q];
            if (elig[q] && strict_m[q]) begin
                s_hit   = 1'b1;
                s_q_idx = QIDX_W'(q);
            end
        end
    end

    // weighted pick with reload when credit is exhausted
    always_comb begin
        live = 1'b0;
        for (int q = 0; q < QPC; q++) begin
            if (wrr_el[q] && s_q.credit[q] != '0) live = 1'b1;
        end
        for (int q = 0; q < QPC; q++) begin
            if (live)               eff[q] = s_q.credit[q];
            else if (wt[q] == '0)   eff[q] = WT_W'(1);
            else                    eff[q] = wt[q];
        end
        w_hit   = 1'b0;
        w_q_idx = '0;
        idx     = '0;
        for (int i = 0; i < QPC; i++) begin
            idx = s_q.ptr + QIDX_W'(i);
            if (!w_hit && wrr_el[idx] && eff[idx] != '0) begin
                w_hit   = 1'b1;
                w_q_idx = idx;
            end
        end
        left = eff[w_q_idx] - WT_W'(1);
    end

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (sel && !s_hit) begin
            s_d.credit = eff;
            if (w_hit) begin
                s_d.credit[w_q_idx] = left;
                s_d.ptr = (left == '0) ? w_q_idx + QIDX_W'(1) : w_q_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit   = s_hit || w_hit;
    assign hit_q = s_hit ? s_q_idx : w_q_idx;
endmodule

// File: rtl/egress_qsched.sv
module egress_qsched
    import egress_qsched_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [NUM_CH*QPC-1:0] q_ready,
    input  logic                  req_valid,
    input  logic [CH_W-1:0]       req_ch,
    output logic                  gnt_valid,
    output logic [CH_W-1:0]       gnt_ch,
    output logic [QIDX_W-1:0]     gnt_q
);
    localparam int NQ = NUM_CH * QPC;

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   ch;
        logic [QIDX_W-1:0] q;
    } gnt_t;

    logic [NUM_CH*MODE_W-1:0]   mode;
    logic [NQ-1:0]              dis_vec;
    logic [NQ-1:0][WT_W-1:0]    wt;
    logic                       mode_clr;
    logic                       cmd_pend;
    logic                       cmd_done;
    logic [NQ-1:0]              elig;
    logic [NUM_CH-1:0]          ch_hit;
    logic [NUM_CH-1:0][QIDX_W-1:0] ch_q;

    egress_qsched_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mode      (mode),
        .dis       (dis_vec),
        .wt        (wt),
        .mode_clr  (mode_clr),
        .pend      (cmd_pend),
        .done      (cmd_done)
    );

    assign elig = q_ready & ~dis_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = req_valid && (int'(req_ch) == c);
        egress_qsched_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_clr),
            .sel   (sel),
            .mode  (mode[c*MODE_W +: MODE_W]),
            .wt    (wt[c*QPC +: QPC]),
            .elig  (elig[c*QPC +: QPC]),
            .hit   (ch_hit[c]),
            .hit_q (ch_q[c])
        );
    end

    gnt_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.vld = 1'b0;
        if (req_valid && int'(req_ch) < NUM_CH) begin
            g_d.vld = ch_hit[req_ch];
            g_d.ch  = req_ch;
            g_d.q   = ch_q[req_ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign gnt_valid = g_q.vld;
    assign gnt_ch    = g_q.ch;
    assign gnt_q     = g_q.q;
endmodule

// File: rtl/egress_qsched_chk.sv
module egress_qsched_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [1:0]          cfg_addr,
    input logic [31:0]         cfg_wdata,
    input logic [NUM_CH*8-1:0] q_ready,
    input logic [NUM_CH*8-1:0] dis_vec,
    input logic                req_valid,
    input logic [CH_W-1:0]     req_ch,
    input logic                gnt_valid,
    input logic [CH_W-1:0]     gnt_ch,
    input logic [2:0]          gnt_q,
    input logic                cmd_pend,
    input logic                cmd_done
);
    logic [NUM_CH*8-1:0] rdy_prev;
    logic [NUM_CH*8-1:0] dis_prev;
    logic                cmd_wr;
    int                  gidx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_prev <= '0;
            dis_prev <= '0;
        end else begin
            rdy_prev <= q_ready;
            dis_prev <= dis_vec;
        end
    end

    assign cmd_wr = cfg_we && cfg_addr == 2'd2 && cfg_wdata[31];
    assign gidx   = int'(gnt_ch) * 8 + int'(gnt_q);

    a_r2_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !gnt_valid);

    a_r2_channel_echo: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!gnt_valid || gnt_ch == $past(req_ch)));

    a_r3_grant_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> rdy_prev[gidx]);

    a_r3_grant_not_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !dis_prev[gidx]);

    a_r10_cmd_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (cmd_pend && !cmd_done));

    a_r10_pend_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pend && !cmd_wr) |=> (cmd_done && !cmd_pend));
endmodule

bind egress_qsched egress_qsched_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .q_ready   (q_ready),
    .dis_vec   (dis_vec),
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch),
    .gnt_q     (gnt_q),
    .cmd_pend  (cmd_pend),
    .cmd_done  (cmd_done)
);

// File: tb/test_egress_qsched.sv
module test_egress_qsched;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] q_ready = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ch = '0;
    logic        gnt_valid;
    logic [1:0]  gnt_ch;
    logic [2:0]  gnt_q;

    egress_qsched #(.NUM_CH(NCH)) i_egress_qsched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .q_ready(q_ready),
        .req_valid(req_valid), .req_ch(req_ch), .gnt_valid(gnt_valid),
        .gnt_ch(gnt_ch), .gnt_q(gnt_q)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    errors  = 0;
    string tag     = "R1";
    bit    finished = 1'b0;

    // reference state
    int m_mode [NCH];
    bit m_dis  [32];
    int m_wt   [NCH][8];
    int m_cr   [NCH][8];
    int m_ptr  [NCH];
    bit exp_v;
    int exp_ch, exp_q;

    function automatic int nstrict(int m);
        if (m == 0) return 0;
        if (m == 1) return 8;
        return m - 1;
    endfunction

    function automatic bit elig(int c, int q);
        return q_ready[c*8+q] && !m_dis[c*8+q];
    endfunction

    task automatic model_grant(int c);
        int  n;
        bit  live;
        n = nstrict(m_mode[c]);
        for (int q = 0; q < n; q++) begin
            if (elig(c, q)) begin
                exp_v = 1; exp_ch = c; exp_q = q;
                return;
            end
        end
        live = 0;
        for (int q = n; q < 8; q++) if (elig(c, q) && m_cr[c][q] > 0) live = 1;
        if (!live) for (int q = 0; q < 8; q++) m_cr[c][q] = (m_wt[c][q] == 0) ? 1 : m_wt[c][q];
        for (int i = 0; i < 8; i++) begin
            int q;
            q = (m_ptr[c] + i) % 8;
            if (q >= n && elig(c, q) && m_cr[c][q] > 0) begin
                m_cr[c][q]--;
                m_ptr[c] = (m_cr[c][q] == 0) ? (q + 1) % 8 : q;
                exp_v = 1; exp_ch = c; exp_q = q;
                return;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_ptr[c] = 0;
                for (int q = 0; q < 8; q++) begin m_wt[c][q] = 0; m_cr[c][q] = 0; end
            end
            for (int b = 0; b < 32; b++) m_dis[b] = 0;
            exp_v = 0;
        end else begin
            exp_v = 0;
            if (req_valid) model_grant(int'(req_ch));
            if (cfg_we) begin
                if (cfg_addr == 2'd0) begin
                    for (int c = 0; c < NCH; c++) begin
                        m_mode[c] = int'(cfg_wdata[c*4 +: 3]);
                        m_ptr[c] = 0;
                        for (int q = 0; q < 8; q++) m_cr[c][q] = 0;
                    end
                end else if (cfg_addr == 2'd1) begin
                    for (int b = 0; b < 32; b++) m_dis[b] = cfg_wdata[b];
                end else if (cfg_addr == 2'd2 && cfg_wdata[31]) begin
                    if (int'(cfg_wdata[23:19]) < NCH)
                        m_wt[cfg_wdata[23:19]][cfg_wdata[18:16]] = int'(cfg_wdata[15:0]);
                end
            end
        end
    end

    // grant compare on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (gnt_valid !== exp_v ||
                (exp_v && (int'(gnt_ch) != exp_ch || int'(gnt_q) != exp_q))) begin
                errors++;
                $display("FAIL %s grant: got v=%0b ch=%0d q=%0d expected v=%0b ch=%0d q=%0d",
                         tag, gnt_valid, gnt_ch, gnt_q, exp_v, exp_ch, exp_q);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] e);
        cfg_addr = a;
        #1;
        vectors++;
        if (cfg_rdata !== e) begin
            errors++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, cfg_rdata, e);
        end
    endtask

    task automatic req(input int c, input logic [31:0] rdy);
        q_ready = rdy; req_valid = 1'b1; req_ch = 2'(c);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(int c, int q, int w);
        return {1'b1, 1'b0, 6'b0, 5'(c), 3'(q), 16'(w)};
    endfunction

    task automatic set_weight(int c, int q, int w);
        logic [31:0] f;
        f = {8'b0, 5'(c), 3'(q), 16'(w)};
        wr(2'd2, cmd_word(c, q, w));
        rd_check(2'd2, f | 32'h8000_0000);
        @(negedge clk);
        rd_check(2'd2, f | 32'h4000_0000);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset contents
        tag = "R1";
        rd_check(2'd0, 32'h0);
        rd_check(2'd1, 32'h0);
        rd_check(2'd2, 32'h0);
        @(negedge clk);
        req(0, 32'h0000_00ff);          // R8 zero weights reload as 1
        tag = "R8";
        repeat (10) req(0, 32'h0000_00ff);

        // R2: no request / no eligible queue
        tag = "R2";
        repeat (3) @(negedge clk);
        req(1, 32'h0000_0000);
        req(2, 32'h00ff_0000);
        req(3, 32'hff00_0000);

        // R12/R4/R5: all strict on every channel
        tag = "R12";
        wr(2'd0, 32'h0000_1111);
        rd_check(2'd0, 32'h0000_1111);
        @(negedge clk);
        tag = "R5";
        req(2, 32'h00a4_0000);
        req(2, 32'h0080_0000);
        req(0, 32'h0000_0006);

        // R3: disable bits
        tag = "R3";
        wr(2'd1, 32'h0004_0002);
        rd_check(2'd1, 32'h0004_0002);
        @(negedge clk);
        req(2, 32'h00a4_0000);
        req(0, 32'h0000_0006);
        req(2, 32'h0004_0000);
        wr(2'd1, 32'h0000_0000);

        // R10/R11: weight commands
        tag = "R10";
        set_weight(0, 0, 3);
        set_weight(0, 1, 0);
        set_weight(0, 2, 2);
        set_weight(1, 0, 3);
        set_weight(1, 7, 4);
        wr(2'd2, 32'h0000_0009);       // command bit clear: ignored
        rd_check(2'd2, {8'b0, 5'd1, 3'd7, 16'd4} | 32'h4000_0000);
        @(negedge clk);
        tag = "R11";
        set_weight(5, 0, 1);

        // R6/R7/R4: WRR on ch0, split modes on others
        tag = "R4";
        wr(2'd0, 32'h0000_7130);
        rd_check(2'd0, 32'h0000_7130);
        @(negedge clk);
        tag = "R6";
        repeat (16) req(0, 32'h0000_0007);
        tag = "R7";
        repeat (6) req(0, 32'h0000_0005);
        repeat (4) req(0, 32'h0000_0002);
        tag = "R4";
        req(1, 32'h0000_0300);
        req(1, 32'h0000_8100);
        repeat (8) req(1, 32'h0000_8100);
        tag = "R11";
        repeat (8) req(1, 32'h0000_8100);
        tag = "R4";
        repeat (6) req(3, 32'hc000_0000);
        req(3, 32'hc400_0000);

        // R9: mode rewrite resets credits and pointer
        tag = "R9";
        req(0, 32'h0000_0007);
        wr(2'd0, 32'h0000_7130);
        @(negedge clk);
        repeat (6) req(0, 32'h0000_0007);

        // random sweep against reference
        tag = "R6";
        for (int c = 0; c < NCH; c++)
            for (int q = 0; q < 8; q++) set_weight(c, q, int'($urandom_range(0, 4)));
        for (int blk = 0; blk < 8; blk++) begin
            logic [31:0] mw;
            mw = '0;
            for (int c = 0; c < NCH; c++) mw[c*4 +: 3] = 3'($urandom_range(0, 7));
            wr(2'd0, mw);
            wr(2'd1, $urandom() & $urandom() & $urandom());
            @(negedge clk);
            tag = (blk % 2 == 0) ? "R7" : "R5";
            for (int i = 0; i < 500; i++) begin
                if ($urandom_range(0, 9) < 7) req(int'($urandom_range(0, 3)), $urandom());
                else begin q_ready = $urandom(); @(negedge clk); end
            end
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule